// File: doc/BRIEF.md
# Banked UART Control Register Decoder

This block is the host-facing register file of one UART channel. A host reaches it through a 3-bit address, an 8-bit write bus, separate write and read strobes, and a registered read-data bus. Four registers live here: the line control register, the enhanced feature register, the modem control register and the trigger level register. The block also returns a read-only FIFO-ready status word, which arrives as an input from the FIFO logic elsewhere in the channel.

The map changes with context. Writing the magic value 0xBF into the line control register opens a hidden bank, and address 2 then reaches the enhanced feature register. Bit 6 of the modem control register makes address 7 asymmetric: writes go to the trigger level register and reads return the FIFO-ready word. Bits 7 and 6 of the modem control register are protected and change only while the enhanced-function enable (bit 4 of the enhanced feature register) is set. Bit 7 of the modem control register drives the clock prescaler select. The trigger level register drives the TX and RX FIFO thresholds.

Top module: `uart_bank_regs`

## Requirements
- R1: After a synchronous reset the line control, enhanced feature, modem control and trigger level registers are 0x00, `presc_div4` is 0, `rdata` is 0x00, and both threshold default flags are 1.
- R2: Address 3 always reads and writes the line control register, and reads return the last value written.
- R3: While the line control register holds 0xBF, address 2 reads and writes the enhanced feature register. Bit 4 of that register is the enhanced-function enable.
- R4: While the line control register holds any value other than 0xBF, a read of address 2 returns 0x00 and a write to address 2 leaves the enhanced feature register unchanged.
- R5: Address 4 always reads and writes the modem control register. Bits 5:0 take every written value, and reads return the stored value.
- R6: A write to address 4 updates modem control bits 7:6 only while enhanced feature bit 4 is 1. Otherwise those two bits keep their previous value.
- R7: `presc_div4` equals modem control bit 7 (1 = divide-by-4, 0 = divide-by-1).
- R8: While modem control bit 6 is 1, a write to address 7 loads the trigger level register. `tx_thr_bytes` is 4 × bits 3:0 and `rx_thr_bytes` is 4 × bits 7:4. Each `*_thr_dflt` flag is 1 exactly when its 4-bit field is 0.
- R9: While modem control bit 6 is 1, a read of address 7 returns the `fifo_rdy` input as sampled at the read strobe. No enhanced-function enable is needed for this.
- R10: While modem control bit 6 is 0, address 7 reads 0x00 and writes to it leave the thresholds unchanged. Addresses 0, 1, 5 and 6 always read 0x00 and ignore writes.
- R11: `rdata` is updated on the clock edge that samples `rd_en` = 1 and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| fifo_rdy | input | 8 | FIFO-ready status word from the FIFO logic |
| rdata | output | 8 | Registered read data |
| presc_div4 | output | 1 | Prescaler select, 1 = divide-by-4 |
| tx_thr_bytes | output | 6 | TX FIFO threshold in bytes |
| tx_thr_dflt | output | 1 | TX threshold field is 0, so the default trigger applies |
| rx_thr_bytes | output | 6 | RX FIFO threshold in bytes |
| rx_thr_dflt | output | 1 | RX threshold field is 0, so the default trigger applies |

## Verification
The hardest case to reach is a write to the protected modem control bits while the enable is clear. The host must first open the hidden bank, set the enable, set those bits, and then clear the enable again before it tries to overwrite them. The stimulus table walks through that exact sequence of line control and enhanced feature writes. It then reads address 4 to show that the low bits moved and the high bits did not. Directed tests after the table then close the bank with a non-magic line control value, and confirm that address 2 is hidden and that address 7 changes meaning when bit 6 is cleared.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int THR_W    = 4;
  localparam int BYTES_W  = THR_W + 2;

  localparam logic [DATA_W-1:0] BANK_MAGIC = 8'hBF;

  localparam logic [ADDR_W-1:0] A_BANKED = 3'd2;
  localparam logic [ADDR_W-1:0] A_LINE   = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODEM  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ALIAS  = 3'd7;

  localparam int ENH_BIT   = 4;
  localparam int ALIAS_BIT = 6;
  localparam int PRESC_BIT = 7;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_LINE,
    RS_FEAT,
    RS_MODEM,
    RS_FRDY
  } rsel_e;

  typedef struct packed {
    logic line;
    logic feat;
    logic modem;
    logic trig;
  } wsel_t;
endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_open,
  input  logic              alias_on,
  output wsel_t             wsel,
  output rsel_e             rsel
);
  always_comb begin
    wsel = '0;
    rsel = RS_ZERO;
    unique case (addr)
      A_LINE: begin
        wsel.line = wr_en;
        rsel      = RS_LINE;
      end
      A_MODEM: begin
        wsel.modem = wr_en;
        rsel       = RS_MODEM;
      end
      A_BANKED: begin
        if (bank_open) begin
          wsel.feat = wr_en;
          rsel      = RS_FEAT;
        end
      end
      A_ALIAS: begin
        if (alias_on) begin
          wsel.trig = wr_en;
          rsel      = RS_FRDY;
        end
      end
      default: ;
    endcase
  end

  // R10
  wsel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wsel));
endmodule

// File: rtl/uart_bank_regfile.sv
module uart_bank_regfile
  import uart_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wsel_t             wsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] line_q,
  output logic [DATA_W-1:0] feat_q,
  output logic [DATA_W-1:0] modem_q,
  output logic [DATA_W-1:0] trig_q
);
  localparam int LOW_W = ALIAS_BIT;

  logic unlocked;
  assign unlocked = feat_q[ENH_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      feat_q  <= '0;
      modem_q <= '0;
      trig_q  <= '0;
    end else begin
      if (wsel.line)  line_q <= wdata;
      if (wsel.feat)  feat_q <= wdata;
      if (wsel.trig)  trig_q <= wdata;
      if (wsel.modem) begin
        modem_q[LOW_W-1:0] <= wdata[LOW_W-1:0];
        if (unlocked)
          modem_q[DATA_W-1:LOW_W] <= wdata[DATA_W-1:LOW_W];
      end
    end
  end

  // R6
  modem_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wsel.modem && !unlocked) |=> (modem_q[DATA_W-1:LOW_W] == $past(modem_q[DATA_W-1:LOW_W])));

  // R5
  modem_low_chk: assert property (@(posedge clk) disable iff (rst)
    wsel.modem |=> (modem_q[LOW_W-1:0] == $past(wdata[LOW_W-1:0])));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (line_q == '0 && feat_q == '0 && modem_q == '0 && trig_q == '0));
endmodule

// File: rtl/uart_bank_thresh.sv
module uart_bank_thresh
  import uart_bank_pkg::*;
#(
  parameter int CHANNELS = 2
) (
  input  logic [CHANNELS*THR_W-1:0]   trig_q,
  output logic [CHANNELS*BYTES_W-1:0] thr_bytes,
  output logic [CHANNELS-1:0]         thr_dflt
);
  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    logic [THR_W-1:0] field;
    assign field = trig_q[i*THR_W +: THR_W];
    assign thr_bytes[i*BYTES_W +: BYTES_W] = {field, 2'b00};
    assign thr_dflt[i] = (field == '0);
  end
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] fifo_rdy,
  output logic [DATA_W-1:0] rdata,
  output logic              presc_div4,
  output logic [BYTES_W-1:0] tx_thr_bytes,
  output logic              tx_thr_dflt,
  output logic [BYTES_W-1:0] rx_thr_bytes,
  output logic              rx_thr_dflt
);
  logic [DATA_W-1:0] line_q, feat_q, modem_q, trig_q;
  wsel_t wsel;
  rsel_e rsel;
  logic  bank_open, alias_on;
  logic [2*BYTES_W-1:0] thr_bytes;
  logic [1:0]           thr_dflt;
  logic [DATA_W-1:0]    rd_mux;

  assign bank_open = (line_q == BANK_MAGIC);
  assign alias_on  = modem_q[ALIAS_BIT];

  uart_bank_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .bank_open (bank_open),
    .alias_on  (alias_on),
    .wsel      (wsel),
    .rsel      (rsel)
  );

  uart_bank_regfile u_rf (
    .clk     (clk),
    .rst     (rst),
    .wsel    (wsel),
    .wdata   (wdata),
    .line_q  (line_q),
    .feat_q  (feat_q),
    .modem_q (modem_q),
    .trig_q  (trig_q)
  );

  uart_bank_thresh #(.CHANNELS(2)) u_thr (
    .trig_q    (trig_q),
    .thr_bytes (thr_bytes),
    .thr_dflt  (thr_dflt)
  );

  assign tx_thr_bytes = thr_bytes[0 +: BYTES_W];
  assign rx_thr_bytes = thr_bytes[BYTES_W +: BYTES_W];
  assign tx_thr_dflt  = thr_dflt[0];
  assign rx_thr_dflt  = thr_dflt[1];
  assign presc_div4   = modem_q[PRESC_BIT];

  always_comb begin
    unique case (rsel)
      RS_LINE:  rd_mux = line_q;
      RS_FEAT:  rd_mux = feat_q;
      RS_MODEM: rd_mux = modem_q;
      RS_FRDY:  rd_mux = fifo_rdy;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R9
  frdy_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_ALIAS && modem_q[ALIAS_BIT]) |=> (rdata == $past(fifo_rdy)));

  // R4
  feat_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_BANKED && line_q != BANK_MAGIC) |=> $stable(feat_q));

  // R10
  alias_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ALIAS && !modem_q[ALIAS_BIT]) |=> $stable(trig_q));
endmodule

// File: tb/uart_bank_regs_tb_top.sv
module uart_bank_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, fifo_rdy = 8'h5A;
  logic [7:0] rdata;
  logic       presc_div4, tx_thr_dflt, rx_thr_dflt;
  logic [5:0] tx_thr_bytes, rx_thr_bytes;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  uart_bank_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .fifo_rdy(fifo_rdy), .rdata(rdata), .presc_div4(presc_div4),
    .tx_thr_bytes(tx_thr_bytes), .tx_thr_dflt(tx_thr_dflt),
    .rx_thr_bytes(rx_thr_bytes), .rx_thr_dflt(rx_thr_dflt)
  );

  // entry: {is_read(1), req(4), addr(3), data(8), expect(8)}
  localparam int NV = 19;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 4'd2,  3'd3, 8'h00, 8'h00},  // R2 line reg after reset
    {1'b0, 4'd2,  3'd3, 8'hBF, 8'h00},  // open bank
    {1'b1, 4'd2,  3'd3, 8'h00, 8'hBF},  // R2 readback
    {1'b0, 4'd3,  3'd2, 8'h10, 8'h00},  // R3 set enable
    {1'b1, 4'd3,  3'd2, 8'h00, 8'h10},  // R3 feature readback
    {1'b0, 4'd2,  3'd3, 8'h03, 8'h00},  // close bank
    {1'b1, 4'd4,  3'd2, 8'h00, 8'h00},  // R4 hidden read
    {1'b0, 4'd4,  3'd2, 8'hFF, 8'h00},  // R4 write ignored
    {1'b0, 4'd2,  3'd3, 8'hBF, 8'h00},  // reopen
    {1'b1, 4'd4,  3'd2, 8'h00, 8'h10},  // R4 feature unchanged
    {1'b0, 4'd5,  3'd4, 8'hC5, 8'h00},  // unlocked modem write
    {1'b1, 4'd5,  3'd4, 8'h00, 8'hC5},  // R5 readback
    {1'b0, 4'd6,  3'd2, 8'h00, 8'h00},  // clear enable
    {1'b0, 4'd6,  3'd4, 8'h0A, 8'h00},  // locked modem write
    {1'b1, 4'd6,  3'd4, 8'h00, 8'hCA},  // R6 high bits kept
    {1'b1, 4'd9,  3'd7, 8'h00, 8'h5A},  // R9 fifo ready via alias
    {1'b0, 4'd8,  3'd7, 8'h83, 8'h00},  // R8 load trigger level
    {1'b1, 4'd10, 3'd0, 8'h00, 8'h00},  // R10 unserved addr
    {1'b1, 4'd10, 3'd5, 8'h00, 8'h00}   // R10 unserved addr
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 presc", {7'd0, presc_div4}, 8'h00);
    chk("R1 dflt", {6'd0, rx_thr_dflt, tx_thr_dflt}, 8'h03);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23]) begin
        rd(VEC[i][18:16]);
        chk($sformatf("R%0d vec%0d", VEC[i][22:19], i), rdata, VEC[i][7:0]);
      end else begin
        wr(VEC[i][18:16], VEC[i][15:8]);
      end
    end

    // R8 thresholds from 0x83
    chk("R8 tx bytes", {2'b0, tx_thr_bytes}, 8'd12);
    chk("R8 rx bytes", {2'b0, rx_thr_bytes}, 8'd32);
    chk("R8 dflt", {6'd0, rx_thr_dflt, tx_thr_dflt}, 8'h00);
    // R7 prescaler set
    chk("R7 div4", {7'd0, presc_div4}, 8'h01);

    // R11 hold without strobe
    rd(3'd7);
    fifo_rdy = 8'hA3;
    repeat (2) @(negedge clk);
    chk("R11 hold", rdata, 8'h5A);
    rd(3'd7);
    chk("R9 new sample", rdata, 8'hA3);

    // unlock and clear modem entirely
    wr(3'd2, 8'h10);
    wr(3'd4, 8'h00);
    chk("R7 div1", {7'd0, presc_div4}, 8'h00);
    rd(3'd7);
    chk("R10 alias off read", rdata, 8'h00);
    wr(3'd7, 8'hF0);
    chk("R10 tx unchanged", {2'b0, tx_thr_bytes}, 8'd12);
    chk("R10 rx unchanged", {2'b0, rx_thr_bytes}, 8'd32);
    wr(3'd6, 8'hFF);
    rd(3'd6);
    chk("R10 addr6", rdata, 8'h00);

    // R4 close bank with non-magic near value
    wr(3'd3, 8'hBE);
    rd(3'd2);
    chk("R4 near magic", rdata, 8'h00);

    // R8 zero field -> default, tx only
    wr(3'd4, 8'h40);
    wr(3'd7, 8'h50);
    chk("R8 tx dflt", {7'd0, tx_thr_dflt}, 8'h01);
    chk("R8 rx bytes 20", {2'b0, rx_thr_bytes}, 8'd20);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 presc after rst", {7'd0, presc_div4}, 8'h00);
    chk("R1 dflt after rst", {6'd0, rx_thr_dflt, tx_thr_dflt}, 8'h03);
    rd(3'd3);
    chk("R1 line after rst", rdata, 8'h00);
    rd(3'd4);
    chk("R1 modem after rst", rdata, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule